// File: doc/BRIEF.md
# Thresholding Bit Receiver with Neighbour Crosstalk Correction

This block turns a raster-scanned grid of multi-bit detector intensities back into on-off bits. Each sample arrives with its row and column, a channel flag (activation or weight) and the bit that was meant to be sent. The block subtracts a per-pixel dark level and scales the rest by a per-pixel reciprocal gain. Both calibration values are kept in small internal memories that are loaded through a write port. The stored dark level is a frame taken with every source off. The stored gain is derived from a frame taken with every source on.

Crosstalk is assumed to be the same across the whole array. To correct it, the block takes a programmable fraction of the sum of the four orthogonal neighbours and subtracts it from the pixel. The result is compared with the threshold of the pixel's channel. A bypass input selects the uncorrected decision, and the uncorrected decision is also output at all times. A correction needs the row below, so the decision for row r is issued while row r+1 streams in. The last row is issued by itself once the frame ends. A checker counts the bits issued and the bits that differ from the expected ones, which gives the bit error rate.

Top module: `optbit_receiver`

## Requirements
- R1: After a synchronous active-low reset, `bit_valid` is 0 and both counters read 0.
- R2: The normalised value is floor(max(x − bg, 0) · g / 2^16), clamped to 2^PIX_W − 1. Here x is the sample, and bg and g are the dark level and the unsigned Q0.16 reciprocal gain written at address row·COLS + col.
- R3: The corrected value is max(0, n − floor(f · S / 256)). Here n is the pixel's normalised value, S is the sum of its four orthogonal neighbours' normalised values, and f is the 8-bit `xt_frac` input.
- R4: A neighbour that lies outside the grid (above row 0, below the last row, left of column 0 or right of the last column) contributes 0 to S.
- R5: Channel 0 (activation) uses `thr_act` and channel 1 (weight) uses `thr_wgt`. A value strictly greater than the threshold decodes to 1, and any other value decodes to 0.
- R6: `bit_raw` is always the threshold decision on the uncorrected normalised value. When `bypass` is 1, `bit_out` equals that decision. When `bypass` is 0, `bit_out` is the decision on the corrected value.
- R7: A sample in row 0 produces no output. A sample at (r, c) with r ≥ 1 makes `bit_valid` high in the next cycle, with the decision for pixel (r−1, c) on `bit_row` and `bit_col`.
- R8: After the sample at the last row and last column is accepted, the last row's decisions come out on COLS consecutive cycles, column 0 first, starting two cycles after that acceptance, with the neighbour below taken as 0. No sample may arrive during these cycles.
- R9: Each output bit adds 1 to `bit_cnt`. It also adds 1 to `err_cnt` when `bit_out` differs from the expected bit given with that pixel. Both counters are 32 bits wide and hold at all-ones instead of wrapping.
- R10: `cnt_clr` sets both counters to 0 on the next clock edge, and it takes precedence over any increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_we | input | 1 | Calibration write enable |
| cal_addr | input | ADDR_W | Pixel address row·COLS+col |
| cal_bg | input | PIX_W | Dark level to store |
| cal_gain | input | GAIN_W | Reciprocal gain to store, unsigned Q0.16 |
| xt_frac | input | FRAC_W | Crosstalk fraction, Q0.8 |
| thr_act | input | PIX_W | Threshold for channel 0 |
| thr_wgt | input | PIX_W | Threshold for channel 1 |
| bypass | input | 1 | 1 selects the uncorrected decision for `bit_out` |
| px_valid | input | 1 | Sample valid |
| px_row | input | ROW_W | Sample row |
| px_col | input | COL_W | Sample column |
| px_data | input | PIX_W | Sample intensity |
| px_chan | input | 1 | Sample channel, 0 activation, 1 weight |
| px_exp | input | 1 | Expected bit for this pixel |
| cnt_clr | input | 1 | Synchronous counter clear |
| bit_valid | output | 1 | Decision valid |
| bit_row | output | ROW_W | Row of the decided pixel |
| bit_col | output | COL_W | Column of the decided pixel |
| bit_out | output | 1 | Selected decision |
| bit_raw | output | 1 | Uncorrected decision |
| err_cnt | output | 32 | Mismatched bits, saturating |
| bit_cnt | output | 32 | Compared bits, saturating |

## Verification
The block is driven with several kinds of frame. Uniformly lit frames make interior, edge and corner pixels come out differently, because each has a different number of in-grid neighbours. Random frames with mixed channels and a moderate fraction separate the corrected decision from the raw one. Frames whose samples fall below the dark level exercise the clamp at zero. A frame in bypass mode shows that the raw path alone drives `bit_out`. Idle gaps inside a row check that the output stays tied to each accepted sample and not to free-running time. Random expected bits give nonzero error counts, and those counts are compared before and after a clear.

// File: rtl/optbit_pkg.sv
`timescale 1ns/1ps
// Shared types for the bit receiver.
// Assumes: channel encoding 0 = activation, 1 = weight.
package optbit_pkg;
    localparam int CNT_W = 32;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef enum logic {CH_ACT = 1'b0, CH_WGT = 1'b1} chan_e;
endpackage

// File: rtl/optbit_calib.sv
`timescale 1ns/1ps
// Per-pixel dark subtraction and gain normalisation.
// Holds one dark level and one reciprocal gain per pixel, loaded by a write port.
// Assumes: the read address is valid whenever the result is used; the output is combinational.
module optbit_calib #(
    parameter int PIX_W     = 10,
    parameter int GAIN_W    = 16,
    parameter int GAIN_IBITS = 0,
    parameter int DEPTH     = 48,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              cal_we,
    input  logic [ADDR_W-1:0] cal_addr,
    input  logic [PIX_W-1:0]  cal_bg,
    input  logic [GAIN_W-1:0] cal_gain,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [PIX_W-1:0]  px_data,
    output logic [PIX_W-1:0]  norm
);
    localparam int GFRAC  = GAIN_W - GAIN_IBITS;
    localparam int PROD_W = PIX_W + GAIN_W;
    localparam logic [PROD_W-1:0] FULL = PROD_W'((1 << PIX_W) - 1);

    logic [PIX_W-1:0]  bg_mem   [DEPTH];
    logic [GAIN_W-1:0] gain_mem [DEPTH];
    logic [PIX_W-1:0]  dark;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;

    // Store calibration values written by the host
    always_ff @(posedge clk) begin
        if (cal_we) begin
            bg_mem[cal_addr]   <= cal_bg;
            gain_mem[cal_addr] <= cal_gain;
        end
    end

    // Dark subtraction clamped at zero, then gain scaling clamped at full scale
    always_comb begin
        dark   = (px_data > bg_mem[rd_addr]) ? px_data - bg_mem[rd_addr] : '0;
        prod   = PROD_W'(dark) * PROD_W'(gain_mem[rd_addr]);
        scaled = prod >> GFRAC;
        norm   = (scaled > FULL) ? FULL[PIX_W-1:0] : scaled[PIX_W-1:0];
    end
endmodule

// File: rtl/optbit_xtalk.sv
`timescale 1ns/1ps
// Crosstalk correction and threshold decision over a 3x3 cross window.
// Two row buffers (selected by row parity) hold normalised values, channel and
// expected bit. A sample in row r+1 releases the decision for row r; after the
// last pixel of a frame the last row is drained on COLS consecutive cycles.
// Assumes: raster order, full frames, ROWS >= 2, no sample during the drain.
module optbit_xtalk
    import optbit_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int ROWS   = 6,
    parameter int COLS   = 8,
    parameter int FRAC_W = 8,
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [COL_W-1:0]  in_col,
    input  logic [PIX_W-1:0]  in_norm,
    input  logic              in_chan,
    input  logic              in_exp,
    input  logic [FRAC_W-1:0] xt_frac,
    input  logic [PIX_W-1:0]  thr_act,
    input  logic [PIX_W-1:0]  thr_wgt,
    input  logic              bypass,
    output logic              o_valid,
    output logic [ROW_W-1:0]  o_row,
    output logic [COL_W-1:0]  o_col,
    output logic              o_bit,
    output logic              o_raw,
    output logic              o_exp
);
    localparam int SUM_W = PIX_W + 2;
    localparam int MUL_W = SUM_W + FRAC_W;
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    logic [PIX_W-1:0] lb_val  [2][COLS];
    logic             lb_chan [2][COLS];
    logic             lb_exp  [2][COLS];

    logic             drain_on;
    logic [COL_W-1:0] drain_col;

    logic             emit;
    logic [ROW_W-1:0] e_row;
    logic [COL_W-1:0] e_col;
    logic             cur;
    logic [PIX_W-1:0] ctr, up, dn, lf, rt, thr;
    logic [SUM_W-1:0] nsum;
    logic [MUL_W-1:0] leak;
    logic [PIX_W-1:0] fixed;
    logic             e_chan, e_exp;

    // Write each accepted sample into the buffer of its row parity
    always_ff @(posedge clk) begin
        if (in_valid) begin
            lb_val[in_row[0]][in_col]  <= in_norm;
            lb_chan[in_row[0]][in_col] <= in_chan;
            lb_exp[in_row[0]][in_col]  <= in_exp;
        end
    end

    // Drain sequencer for the last row of a frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drain_on  <= 1'b0;
            drain_col <= '0;
        end else if (in_valid && in_row == LAST_ROW && in_col == LAST_COL) begin
            drain_on  <= 1'b1;
            drain_col <= '0;
        end else if (drain_on) begin
            drain_on  <= (drain_col != LAST_COL);
            drain_col <= drain_col + 1'b1;
        end
    end

    // Pick the pixel to decide and gather its window, zero outside the grid
    always_comb begin
        emit   = drain_on || (in_valid && in_row != '0);
        e_row  = drain_on ? LAST_ROW : in_row - 1'b1;
        e_col  = drain_on ? drain_col : in_col;
        cur    = e_row[0];
        ctr    = lb_val[cur][e_col];
        e_chan = lb_chan[cur][e_col];
        e_exp  = lb_exp[cur][e_col];
        dn     = drain_on ? '0 : in_norm;
        up     = (e_row == '0) ? '0 : lb_val[~cur][e_col];
        lf     = (e_col == '0) ? '0 : lb_val[cur][e_col - 1'b1];
        rt     = (e_col == LAST_COL) ? '0 : lb_val[cur][e_col + 1'b1];
    end

    // Neighbour leak estimate and corrected value clamped at zero
    always_comb begin
        nsum  = SUM_W'(up) + SUM_W'(dn) + SUM_W'(lf) + SUM_W'(rt);
        leak  = (MUL_W'(nsum) * MUL_W'(xt_frac)) >> FRAC_W;
        fixed = (MUL_W'(ctr) > leak) ? ctr - leak[PIX_W-1:0] : '0;
        thr   = (chan_e'(e_chan) == CH_WGT) ? thr_wgt : thr_act;
    end

    // Register the decision with its position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_row   <= '0;
            o_col   <= '0;
            o_bit   <= 1'b0;
            o_raw   <= 1'b0;
            o_exp   <= 1'b0;
        end else begin
            o_valid <= emit;
            if (emit) begin
                o_row <= e_row;
                o_col <= e_col;
                o_raw <= (ctr > thr);
                o_bit <= bypass ? (ctr > thr) : (fixed > thr);
                o_exp <= e_exp;
            end
        end
    end

    AST_DRAIN_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n) drain_on |-> !in_valid); // R8
    AST_EMIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_row != '0) |=> o_valid); // R7
    AST_ROW0_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_row == '0 && !drain_on) |=> !o_valid); // R7
    AST_DRAIN_ROW: assert property (@(posedge clk) disable iff (!rst_n) drain_on |=> (o_valid && o_row == LAST_ROW)); // R8
endmodule

// File: rtl/optbit_tally.sv
`timescale 1ns/1ps
// Bit and error counters for bit error rate measurement.
// Saturating counters with a synchronous clear that wins over counting.
// CHECK_EN = 0 builds no counters and drives zeros.
module optbit_tally
    import optbit_pkg::*;
#(
    parameter bit CHECK_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic valid,
    input  logic got,
    input  logic want,
    output cnt_t err_cnt,
    output cnt_t bit_cnt
);
    generate
        if (CHECK_EN) begin : g_count
            // Count compared bits and mismatches, hold at all-ones
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    err_cnt <= '0;
                    bit_cnt <= '0;
                end else if (valid) begin
                    if (bit_cnt != '1)
                        bit_cnt <= bit_cnt + 1'b1;
                    if (got != want && err_cnt != '1)
                        err_cnt <= err_cnt + 1'b1;
                end
            end

            AST_ERR_LE_BITS: assert property (@(posedge clk) disable iff (!rst_n) err_cnt <= bit_cnt); // R9
            AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (err_cnt == '0 && bit_cnt == '0)); // R10
            AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!clr && valid && bit_cnt != '1) |=> bit_cnt == $past(bit_cnt) + 1'b1); // R9
            AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (!clr && bit_cnt == '1) |=> bit_cnt == '1); // R9
        end else begin : g_none
            assign err_cnt = '0;
            assign bit_cnt = '0;
        end
    endgenerate
endmodule

// File: rtl/optbit_receiver.sv
`timescale 1ns/1ps
// Top level of the thresholding bit receiver.
// Sample -> calibration (combinational) -> crosstalk window and decision
// (one register) -> counters. Output for row r follows the row r+1 sample by one cycle.
// Assumes: raster-ordered complete frames and calibration loaded before use.
module optbit_receiver
    import optbit_pkg::*;
#(
    parameter int ROWS       = 6,
    parameter int COLS       = 8,
    parameter int PIX_W      = 10,
    parameter int GAIN_W     = 16,
    parameter int GAIN_IBITS = 0,
    parameter int FRAC_W     = 8,
    parameter bit CHECK_EN   = 1'b1,
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int DEPTH  = ROWS * COLS,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_we,
    input  logic [ADDR_W-1:0] cal_addr,
    input  logic [PIX_W-1:0]  cal_bg,
    input  logic [GAIN_W-1:0] cal_gain,
    input  logic [FRAC_W-1:0] xt_frac,
    input  logic [PIX_W-1:0]  thr_act,
    input  logic [PIX_W-1:0]  thr_wgt,
    input  logic              bypass,
    input  logic              px_valid,
    input  logic [ROW_W-1:0]  px_row,
    input  logic [COL_W-1:0]  px_col,
    input  logic [PIX_W-1:0]  px_data,
    input  logic              px_chan,
    input  logic              px_exp,
    input  logic              cnt_clr,
    output logic              bit_valid,
    output logic [ROW_W-1:0]  bit_row,
    output logic [COL_W-1:0]  bit_col,
    output logic              bit_out,
    output logic              bit_raw,
    output logic [31:0]       err_cnt,
    output logic [31:0]       bit_cnt
);
    logic [ADDR_W-1:0] rd_addr;
    logic [PIX_W-1:0]  norm;
    logic              dec_exp;

    // Pixel address for the calibration lookup
    assign rd_addr = ADDR_W'(int'(px_row) * COLS + int'(px_col));

    optbit_calib #(
        .PIX_W(PIX_W), .GAIN_W(GAIN_W), .GAIN_IBITS(GAIN_IBITS),
        .DEPTH(DEPTH), .ADDR_W(ADDR_W)
    ) i_calib (
        .clk(clk), .cal_we(cal_we), .cal_addr(cal_addr), .cal_bg(cal_bg),
        .cal_gain(cal_gain), .rd_addr(rd_addr), .px_data(px_data), .norm(norm)
    );

    optbit_xtalk #(
        .PIX_W(PIX_W), .ROWS(ROWS), .COLS(COLS), .FRAC_W(FRAC_W),
        .ROW_W(ROW_W), .COL_W(COL_W)
    ) i_xtalk (
        .clk(clk), .rst_n(rst_n), .in_valid(px_valid), .in_row(px_row),
        .in_col(px_col), .in_norm(norm), .in_chan(px_chan), .in_exp(px_exp),
        .xt_frac(xt_frac), .thr_act(thr_act), .thr_wgt(thr_wgt), .bypass(bypass),
        .o_valid(bit_valid), .o_row(bit_row), .o_col(bit_col), .o_bit(bit_out),
        .o_raw(bit_raw), .o_exp(dec_exp)
    );

    optbit_tally #(.CHECK_EN(CHECK_EN)) i_tally (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .valid(bit_valid),
        .got(bit_out), .want(dec_exp), .err_cnt(err_cnt), .bit_cnt(bit_cnt)
    );

    AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n) (bit_valid && $past(bypass)) |-> bit_out == bit_raw); // R6
    AST_RESET_QUIET: assert property (@(posedge clk) $past(!rst_n) |-> (!bit_valid && err_cnt == '0)); // R1
endmodule

// File: tb/test_optbit_receiver.sv
`timescale 1ns/1ps
module test_optbit_receiver;
    localparam int ROWS = 6, COLS = 8, PIX_W = 10, FS = (1 << PIX_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cal_we = 0; logic [5:0] cal_addr = '0; logic [9:0] cal_bg = '0; logic [15:0] cal_gain = '0;
    logic [7:0] xt_frac = '0; logic [9:0] thr_act = '0, thr_wgt = '0; logic bypass = 0;
    logic px_valid = 0; logic [2:0] px_row = '0, px_col = '0; logic [9:0] px_data = '0;
    logic px_chan = 0, px_exp = 0, cnt_clr = 0;
    logic bit_valid, bit_out, bit_raw; logic [2:0] bit_row, bit_col; logic [31:0] err_cnt, bit_cnt;

    optbit_receiver i_optbit_receiver (.*);

    always #2.5 clk = ~clk;

    int n_tests = 0, n_fail = 0, cyc = 0;
    int bgv[ROWS][COLS], gnv[ROWS][COLS], nrm[ROWS][COLS], chv[ROWS][COLS], exv[ROWS][COLS];
    int dat[ROWS][COLS];
    int q_due[$], q_row[$], q_col[$], q_bit[$], q_raw[$], q_drn[$];
    int exp_bits = 0, exp_errs = 0;
    string tag = "R1";
    bit done = 0;

    task automatic chk(bit ok, string req, int act, int expv, string what);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    function automatic int getn(int r, int c);
        if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 0;
        return nrm[r][c];
    endfunction

    // Output comparison on every clock, away from the edge
    always @(posedge clk) begin
        #1;
        cyc++;
        if (rst_n) begin
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                string t = q_drn[0] ? "R8" : tag;
                chk(bit_valid == 1'b1, q_drn[0] ? "R8" : "R7", int'(bit_valid), 1, "valid");
                chk(int'(bit_row) == q_row[0] && int'(bit_col) == q_col[0], q_drn[0] ? "R8" : "R7",
                    int'(bit_row) * 100 + int'(bit_col), q_row[0] * 100 + q_col[0], "row*100+col");
                chk(int'(bit_out) == q_bit[0], t, int'(bit_out), q_bit[0], "bit_out");
                chk(int'(bit_raw) == q_raw[0], "R6", int'(bit_raw), q_raw[0], "bit_raw");
                void'(q_due.pop_front()); void'(q_row.pop_front()); void'(q_col.pop_front());
                void'(q_bit.pop_front()); void'(q_raw.pop_front()); void'(q_drn.pop_front());
            end else begin
                chk(bit_valid == 1'b0, "R7", int'(bit_valid), 0, "idle valid");
            end
        end
    end

    task automatic push_dec(int r, int c, int due, int drn);
        int s, leak, fx, thr, raw, cor, ob;
        s = getn(r - 1, c) + getn(r + 1, c) + getn(r, c - 1) + getn(r, c + 1);
        leak = (int'(xt_frac) * s) >>> 8;
        fx = (nrm[r][c] > leak) ? nrm[r][c] - leak : 0;
        thr = chv[r][c] ? int'(thr_wgt) : int'(thr_act);
        raw = (nrm[r][c] > thr) ? 1 : 0;
        cor = (fx > thr) ? 1 : 0;
        ob = bypass ? raw : cor;
        q_due.push_back(due); q_row.push_back(r); q_col.push_back(c);
        q_bit.push_back(ob); q_raw.push_back(raw); q_drn.push_back(drn);
        exp_bits++;
        if (ob != exv[r][c]) exp_errs++;
    endtask

    // pattern: 0 random, 1 uniform bright, 2 below dark level, 3 alternating channels
    task automatic run_frame(int pat, bit gaps);
        int last;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                case (pat)
                    0: dat[r][c] = $urandom_range(FS);
                    1: dat[r][c] = 900;
                    2: dat[r][c] = $urandom_range(20);
                    default: dat[r][c] = $urandom_range(300, FS);
                endcase
                chv[r][c] = (pat == 3) ? ((r + c) % 2) : $urandom_range(1);
                exv[r][c] = $urandom_range(1);
                begin
                    int d = (dat[r][c] > bgv[r][c]) ? dat[r][c] - bgv[r][c] : 0;
                    longint p = longint'(d) * gnv[r][c];
                    int n = int'(p >>> 16);
                    nrm[r][c] = (n > FS) ? FS : n;
                end
            end
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                @(negedge clk);
                if (gaps && c == 4) begin
                    px_valid = 0;
                    @(negedge clk);
                end
                px_valid = 1; px_row = 3'(r); px_col = 3'(c); px_data = 10'(dat[r][c]);
                px_chan = chv[r][c][0]; px_exp = exv[r][c][0];
                if (r > 0) push_dec(r - 1, c, cyc + 1, 0);
                last = cyc;
            end
        for (int c = 0; c < COLS; c++) push_dec(ROWS - 1, c, last + 2 + c, 1);
        @(negedge clk); px_valid = 0;
        repeat (COLS + 3) @(negedge clk);
        chk(q_due.size() == 0, tag, q_due.size(), 0, "pending decisions");
        chk(bit_cnt == 32'(exp_bits), "R9", int'(bit_cnt), exp_bits, "bit_cnt");
        chk(err_cnt == 32'(exp_errs), "R9", int'(err_cnt), exp_errs, "err_cnt");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(7));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(bit_valid == 0, "R1", int'(bit_valid), 0, "valid after reset");
        chk(err_cnt == 0 && bit_cnt == 0, "R1", int'(err_cnt + bit_cnt), 0, "counters after reset");

        // R2: load calibration
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                bgv[r][c] = $urandom_range(63);
                gnv[r][c] = $urandom_range(40000, 65535);
                @(negedge clk);
                cal_we = 1; cal_addr = 6'(r * COLS + c);
                cal_bg = 10'(bgv[r][c]); cal_gain = 16'(gnv[r][c]);
            end
        @(negedge clk); cal_we = 0;

        xt_frac = 8'd64; thr_act = 10'd300; thr_wgt = 10'd450;
        tag = "R3"; run_frame(0, 0);
        tag = "R4"; xt_frac = 8'd64; thr_act = 10'd150; thr_wgt = 10'd150; run_frame(1, 0);
        tag = "R2"; thr_act = 10'd0; thr_wgt = 10'd3; run_frame(2, 0);
        tag = "R5"; xt_frac = 8'd20; thr_act = 10'd100; thr_wgt = 10'd800; run_frame(3, 0);
        tag = "R6"; bypass = 1; xt_frac = 8'd128; thr_act = 10'd300; thr_wgt = 10'd400; run_frame(0, 0);
        bypass = 0;
        tag = "R7"; run_frame(0, 1);

        // R10: clear pulse
        @(negedge clk); cnt_clr = 1;
        @(negedge clk); cnt_clr = 0;
        chk(err_cnt == 0 && bit_cnt == 0, "R10", int'(bit_cnt), 0, "counters after clear");
        exp_bits = 0; exp_errs = 0;
        tag = "R3"; xt_frac = 8'd90; run_frame(0, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule